// File: doc/BRIEF.md
# Receive Frame Queue with Mailbox Release

This block is the receive side of a controller-area-network style peripheral. It sits behind the bit-level receiver and the acceptance logic, and holds up to three complete frames. Each frame carries an identifier, a length code and eight data bytes. The oldest pending frame is always visible on a read-only output mailbox. Software reads the mailbox, then writes a release strobe to discard that frame and bring the next one into view.

The status side reports three things: a two-bit count of pending frames, a full flag and a sticky overrun flag. A lock-mode input selects what happens when a frame arrives while all three slots are occupied. In locked mode the new frame is dropped. In unlocked mode the new frame replaces the newest stored frame. The frame in the mailbox is never touched, so a frame that software is reading cannot be torn by an arriving one.

Releases are sequenced by a two-state machine. REL_IDLE moves to REL_ACTIVE on a release write when at least one frame is pending; a write while the queue is empty leaves it in REL_IDLE. REL_ACTIVE always returns to REL_IDLE after one cycle. That cycle removes the head frame, and the busy flag clears on the same clock edge that moves the mailbox on to the next frame.

Top module: `rxq_top`

## Requirements
- R1: The queue holds up to three frames. `pend_cnt` is the binary number of pending frames: 00 when empty, 11 when three are pending.
- R2: `q_full` is 1 exactly when three frames are pending, and it drops to 0 on the same edge that the count falls below three.
- R3: A one-cycle pulse on `rel_wr` while frames are pending makes `rel_busy` read 1 for exactly one cycle. On the edge where `rel_busy` returns to 0, `pend_cnt` falls by one.
- R4: The mailbox shows the oldest pending frame. It changes to the next frame on the same edge that `rel_busy` clears. While the queue is empty, the mailbox outputs read all zero.
- R5: A `rel_wr` pulse while the queue is empty is ignored: `rel_busy` stays 0 and `pend_cnt` stays 00.
- R6: A `rel_wr` that is still asserted while `rel_busy` is 1 is ignored, so holding `rel_wr` for two cycles removes only one frame.
- R7: With `lock_en`=1, a frame that arrives while the queue is full and no release is completing is discarded. The stored frames come out unchanged and in order.
- R8: With `lock_en`=0, a frame that arrives while the queue is full and no release is completing replaces the newest stored frame. The mailbox frame is unaffected, and the replacement frame drains third.
- R9: Every arrival under the full condition of R7/R8 sets the sticky `ovr_flag`, whatever the lock mode. A `ovr_clr` pulse clears it. When a set and a clear happen in the same cycle, the set wins.
- R10: A frame arriving in the cycle that a release completes is stored, and `pend_cnt` is unchanged. This holds even when the queue was full, and in that case no overrun is flagged.
- R11: After reset, `pend_cnt`=00, `q_full`=0, `ovr_flag`=0, `rel_busy`=0 and the mailbox reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a complete frame is on rx_id/rx_len/rx_data |
| rx_id | input | 29 | Identifier of the arriving frame |
| rx_len | input | 4 | Length code of the arriving frame |
| rx_data | input | 64 | Eight data bytes of the arriving frame |
| lock_en | input | 1 | 1: drop arrivals when full; 0: replace newest frame |
| rel_wr | input | 1 | Write-1 strobe that releases the mailbox frame |
| ovr_clr | input | 1 | Write-1 strobe that clears the overrun flag |
| mb_id | output | 29 | Mailbox identifier |
| mb_len | output | 4 | Mailbox length code |
| mb_data | output | 64 | Mailbox data bytes |
| pend_cnt | output | 2 | Number of pending frames |
| q_full | output | 1 | Three frames pending |
| ovr_flag | output | 1 | Sticky overrun indication |
| rel_busy | output | 1 | Release in progress; reads 1 until the mailbox has advanced |

## Verification
The bench builds the block with its default depth of three. At that depth the two-bit count field is fully used, and every fill level from empty to full is reached within a few frames. This also makes the tail slot and the mailbox slot distinct at full, which is the situation the lock and overwrite policies act on. A small queue also lets the same-cycle cases be driven directly: an arrival during the release cycle at both partial and full occupancy, and an overrun set colliding with a clear.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int FRM_ID_W    = 29;
    localparam int FRM_LEN_W   = 4;
    localparam int FRM_BYTES   = 8;
    localparam int FRM_DATA_W  = FRM_BYTES * 8;

    typedef struct packed {
        logic [FRM_ID_W-1:0]   id;
        logic [FRM_LEN_W-1:0]  len;
        logic [FRM_DATA_W-1:0] data;
    } frame_t;

    typedef enum logic {
        REL_IDLE   = 1'b0,
        REL_ACTIVE = 1'b1
    } rel_state_e;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             ovw,
    input  frame_t           wr_frame,
    output frame_t           head_frame,
    output logic [CNT_W-1:0] count
);

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_prev(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH - 1) : p - PTR_W'(1);
    endfunction

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] tail_ptr;
    frame_t           slot_q [DEPTH];

    assign tail_ptr = ptr_prev(wr_ptr);

    // One register bank per slot; a slot is written by a normal store at
    // the write pointer or by an overwrite of the newest entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic slot_we;
        assign slot_we = (push && (wr_ptr == PTR_W'(i))) ||
                         (ovw  && (tail_ptr == PTR_W'(i)));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (slot_we) begin
                slot_q[i] <= wr_frame;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign head_frame = (count != '0) ? slot_q[rd_ptr] : '0;

endmodule

// File: rtl/rxq_release_fsm.sv
module rxq_release_fsm
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rel_wr,
    input  logic q_empty,
    output logic pop,
    output logic busy
);

    rel_state_e state_q;
    rel_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REL_IDLE:   if (rel_wr && !q_empty) state_d = REL_ACTIVE;
            REL_ACTIVE: state_d = REL_IDLE;
            default:    state_d = REL_IDLE;
        endcase
    end

    always_comb begin
        pop  = 1'b0;
        busy = 1'b0;
        unique case (state_q)
            REL_IDLE:   begin pop = 1'b0; busy = 1'b0; end
            REL_ACTIVE: begin pop = 1'b1; busy = 1'b1; end
            default:    begin pop = 1'b0; busy = 1'b0; end
        endcase
    end

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [FRM_ID_W-1:0]   rx_id,
    input  logic [FRM_LEN_W-1:0]  rx_len,
    input  logic [FRM_DATA_W-1:0] rx_data,
    input  logic                  lock_en,
    input  logic                  rel_wr,
    input  logic                  ovr_clr,
    output logic [FRM_ID_W-1:0]   mb_id,
    output logic [FRM_LEN_W-1:0]  mb_len,
    output logic [FRM_DATA_W-1:0] mb_data,
    output logic [CNT_W-1:0]      pend_cnt,
    output logic                  q_full,
    output logic                  ovr_flag,
    output logic                  rel_busy
);

    frame_t in_frame;
    frame_t head_frame;
    logic   pop;
    logic   accept;
    logic   ovr_hit;
    logic   ovw;

    assign in_frame = '{id: rx_id, len: rx_len, data: rx_data};
    assign q_full   = (pend_cnt == CNT_W'(DEPTH));
    // A release completing this cycle frees a slot for the arrival.
    assign accept   = rx_valid && (!q_full || pop);
    assign ovr_hit  = rx_valid && q_full && !pop;
    assign ovw      = ovr_hit && !lock_en;

    rxq_release_fsm u_rel (
        .clk     (clk),
        .rst_n   (rst_n),
        .rel_wr  (rel_wr),
        .q_empty (pend_cnt == '0),
        .pop     (pop),
        .busy    (rel_busy)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (accept),
        .pop        (pop),
        .ovw        (ovw),
        .wr_frame   (in_frame),
        .head_frame (head_frame),
        .count      (pend_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_flag <= 1'b0;
        end else if (ovr_hit) begin
            ovr_flag <= 1'b1;
        end else if (ovr_clr) begin
            ovr_flag <= 1'b0;
        end
    end

    assign mb_id   = head_frame.id;
    assign mb_len  = head_frame.len;
    assign mb_data = head_frame.data;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rx_valid,
    input logic                  rel_wr,
    input logic [FRM_ID_W-1:0]   mb_id,
    input logic [FRM_LEN_W-1:0]  mb_len,
    input logic [FRM_DATA_W-1:0] mb_data,
    input logic [CNT_W-1:0]      pend_cnt,
    input logic                  q_full,
    input logic                  ovr_flag,
    input logic                  rel_busy
);

    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= CNT_W'(DEPTH));

    a_r3_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rel_busy |=> !rel_busy);

    a_r3_release_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_busy && !rx_valid) |=> (pend_cnt == $past(pend_cnt) - CNT_W'(1)));

    a_r10_store_and_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_busy && rx_valid) |=> (pend_cnt == $past(pend_cnt)));

    a_r5_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!rel_busy && pend_cnt == '0 && rel_wr) |=> !rel_busy);

    a_r4_mailbox_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt != '0 && !rel_busy) |=> ($stable(mb_id) && $stable(mb_len) && $stable(mb_data)));

    a_r9_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && q_full && !rel_busy) |=> ovr_flag);

    a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && q_full && !rel_busy) |=> q_full);

endmodule

bind rxq_top rxq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rel_wr   (rel_wr),
    .mb_id    (mb_id),
    .mb_len   (mb_len),
    .mb_data  (mb_data),
    .pend_cnt (pend_cnt),
    .q_full   (q_full),
    .ovr_flag (ovr_flag),
    .rel_busy (rel_busy)
);

// File: tb/rxq_top_test.sv
`timescale 1ns/1ps
module rxq_top_test;
    import rxq_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  rx_valid = 1'b0;
    logic [FRM_ID_W-1:0]   rx_id = '0;
    logic [FRM_LEN_W-1:0]  rx_len = '0;
    logic [FRM_DATA_W-1:0] rx_data = '0;
    logic                  lock_en = 1'b0;
    logic                  rel_wr = 1'b0;
    logic                  ovr_clr = 1'b0;
    logic [FRM_ID_W-1:0]   mb_id;
    logic [FRM_LEN_W-1:0]  mb_len;
    logic [FRM_DATA_W-1:0] mb_data;
    logic [1:0]            pend_cnt;
    logic                  q_full;
    logic                  ovr_flag;
    logic                  rel_busy;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rxq_top uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_id(rx_id),
        .rx_len(rx_len), .rx_data(rx_data), .lock_en(lock_en),
        .rel_wr(rel_wr), .ovr_clr(ovr_clr), .mb_id(mb_id), .mb_len(mb_len),
        .mb_data(mb_data), .pend_cnt(pend_cnt), .q_full(q_full),
        .ovr_flag(ovr_flag), .rel_busy(rel_busy)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rx_valid = 0; rel_wr = 0; ovr_clr = 0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_frame(input int id);
        rx_id   = FRM_ID_W'(id);
        rx_len  = FRM_LEN_W'(id);
        rx_data = {8{id[7:0]}};
    endtask

    task automatic push(input int id);
        set_frame(id);
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Pulse release, check busy in the middle cycle, return once it clears.
    task automatic release_one(input string tag);
        rel_wr = 1'b1;
        @(negedge clk);
        rel_wr = 1'b0;
        chk_eq({tag, " busy during release"}, rel_busy, 1);
        @(negedge clk);
        chk_eq({tag, " busy cleared"}, rel_busy, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk_eq("R11 count", pend_cnt, 0);
        chk_eq("R11 full", q_full, 0);
        chk_eq("R11 ovr", ovr_flag, 0);
        chk_eq("R11 busy", rel_busy, 0);
        chk_eq("R11 mailbox", mb_id, 0);
    endtask

    task automatic t_fill_drain();
        do_reset();
        push('h21);
        chk_eq("R1 count one", pend_cnt, 1);
        chk_eq("R4 mailbox first", mb_id, 'h21);
        chk_eq("R4 mailbox data", mb_data, {8{8'h21}});
        push('h22);
        chk_eq("R2 not full at two", q_full, 0);
        push('h23);
        chk_eq("R1 count three", pend_cnt, 3);
        chk_eq("R2 full at three", q_full, 1);
        chk_eq("R4 oldest shown", mb_id, 'h21);
        rel_wr = 1'b1;
        @(negedge clk);
        rel_wr = 1'b0;
        chk_eq("R3 busy one", rel_busy, 1);
        chk_eq("R3 count held while busy", pend_cnt, 3);
        chk_eq("R4 mailbox held while busy", mb_id, 'h21);
        @(negedge clk);
        chk_eq("R3 busy clears", rel_busy, 0);
        chk_eq("R3 count drops", pend_cnt, 2);
        chk_eq("R2 full drops", q_full, 0);
        chk_eq("R4 next frame", mb_id, 'h22);
        chk_eq("R4 next len", mb_len, 'h2);
        release_one("R3 second");
        chk_eq("R4 third frame", mb_id, 'h23);
        release_one("R3 third");
        chk_eq("R1 empty", pend_cnt, 0);
        chk_eq("R4 empty mailbox zero", mb_data, 0);
    endtask

    task automatic t_empty_release();
        do_reset();
        rel_wr = 1'b1;
        @(negedge clk);
        rel_wr = 1'b0;
        chk_eq("R5 busy stays low", rel_busy, 0);
        @(negedge clk);
        chk_eq("R5 count stays zero", pend_cnt, 0);
        push('h31);
        chk_eq("R5 later store normal", pend_cnt, 1);
    endtask

    task automatic t_busy_rewrite();
        do_reset();
        push('h41);
        push('h42);
        rel_wr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rel_wr = 1'b0;
        chk_eq("R6 one frame removed", pend_cnt, 1);
        chk_eq("R6 busy low", rel_busy, 0);
        chk_eq("R6 mailbox", mb_id, 'h42);
    endtask

    task automatic t_lock();
        do_reset();
        lock_en = 1'b1;
        push('h51); push('h52); push('h53);
        push('h5F);
        chk_eq("R7 count stays full", pend_cnt, 3);
        chk_eq("R9 overrun set locked", ovr_flag, 1);
        chk_eq("R7 mailbox kept", mb_id, 'h51);
        release_one("R7 a");
        chk_eq("R7 second kept", mb_id, 'h52);
        release_one("R7 b");
        chk_eq("R7 third kept", mb_id, 'h53);
        chk_eq("R7 third data kept", mb_data, {8{8'h53}});
        lock_en = 1'b0;
    endtask

    task automatic t_overwrite();
        do_reset();
        lock_en = 1'b0;
        push('h61); push('h62); push('h63);
        push('h6E);
        chk_eq("R8 count stays full", pend_cnt, 3);
        chk_eq("R9 overrun set unlocked", ovr_flag, 1);
        chk_eq("R8 mailbox untouched", mb_id, 'h61);
        release_one("R8 a");
        chk_eq("R8 second intact", mb_id, 'h62);
        release_one("R8 b");
        chk_eq("R8 newest replaced", mb_id, 'h6E);
        chk_eq("R8 replaced len", mb_len, 'hE);
    endtask

    task automatic t_ovr_clear();
        do_reset();
        push('h71); push('h72); push('h73); push('h74);
        chk_eq("R9 set", ovr_flag, 1);
        set_frame('h75);
        rx_valid = 1'b1; ovr_clr = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; ovr_clr = 1'b0;
        chk_eq("R9 set wins over clear", ovr_flag, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk_eq("R9 cleared", ovr_flag, 0);
        @(negedge clk);
        chk_eq("R9 stays clear", ovr_flag, 0);
    endtask

    task automatic t_simul();
        do_reset();
        push('h81); push('h82);
        rel_wr = 1'b1;
        @(negedge clk);
        rel_wr = 1'b0;
        set_frame('h83);
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        chk_eq("R10 count unchanged", pend_cnt, 2);
        chk_eq("R10 mailbox advanced", mb_id, 'h82);
        release_one("R10 p");
        chk_eq("R10 arrival stored", mb_id, 'h83);
        do_reset();
        push('h91); push('h92); push('h93);
        rel_wr = 1'b1;
        @(negedge clk);
        rel_wr = 1'b0;
        set_frame('h94);
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        chk_eq("R10 full count unchanged", pend_cnt, 3);
        chk_eq("R10 no overrun", ovr_flag, 0);
        release_one("R10 q");
        release_one("R10 r");
        chk_eq("R10 full arrival last", mb_id, 'h94);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_fill_drain();
        t_empty_release();
        t_busy_rewrite();
        t_lock();
        t_overwrite();
        t_ovr_clear();
        t_simul();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule